// File: doc/BRIEF.md
# Vectored Call-Instruction Interrupt Controller

This block collects up to eight interrupt request lines for a CPU with an 8-bit data bus and signals the CPU on one interrupt output. Requests that pass a programmable mask are latched and resolved by fixed priority inside the block, so the CPU only sees one request line. Lower index means higher priority.

When the CPU acknowledges, the block does not return a single vector number. Over three successive acknowledge pulses it supplies a complete three-byte subroutine call instruction: the call opcode, then the low byte and then the high byte of the service routine address. The service address is a programmed 16-bit base plus four bytes per level. The winning level is marked in service on the first pulse. Requests of the same or lower priority are held back until a non-specific end-of-interrupt write retires the highest-priority in-service level. A request of higher priority still nests.

A small write port sets the mask, the two base bytes and the end-of-interrupt command.

Top module: `vec_call_intc`

## Requirements
- R1: After reset, `int_o`, `data_oe_o` and `data_o` are 0, all mask bits are set (every line masked) and the base address is 0x0000.
- R2: A request pulse of one clock on `req_i[n]` is latched. If it is unmasked and eligible, `int_o` is high from the next clock edge on and stays high after the request line drops.
- R3: While mask bit n is 1, request n never drives `int_o` high. The request stays latched, and clearing the mask bit then raises `int_o`. Write address 0 loads the mask from `wr_data_i[N_REQ-1:0]`.
- R4: During the first acknowledge pulse, `data_o` is 0xCD and `data_oe_o` is 1.
- R5: During the second pulse `data_o` is the low byte of the service address, and during the third pulse it is the high byte. The service address is base + 4 × level, modulo 2^16. Write address 1 loads the base low byte and write address 2 loads the base high byte.
- R6: Among eligible requests, the lowest index wins.
- R7: `int_o` is low from the clock edge that samples the first acknowledge rise until the edge that samples the end of the third pulse. The acknowledged request is cleared from pending and does not raise `int_o` again.
- R8: The first acknowledge marks the winning level in service. A pending request of equal or lower priority than any in-service level is held with `int_o` low. A write to address 3, with any data, clears the highest-priority in-service level.
- R9: A request of strictly higher priority than every in-service level raises `int_o` even while lower levels are in service.
- R10: `data_oe_o` follows `inta_i`, and `data_o` is 0 whenever `inta_i` is low.
- R11: The service address is captured on the first acknowledge. Base writes made between pulses do not change the bytes of the sequence already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_REQ | Interrupt request lines, index 0 highest priority |
| int_o | output | 1 | Interrupt request to the CPU |
| inta_i | input | 1 | Interrupt acknowledge from the CPU, active high |
| data_o | output | 8 | Byte returned during acknowledge |
| data_oe_o | output | 1 | Output enable for `data_o` |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 mask, 1 base low, 2 base high, 3 end of interrupt |
| wr_data_i | input | 8 | Register write data |

## Verification
Some conditions are hard to reach from the ports. One is a nested stack of in-service levels with a lower-priority request waiting underneath them. Another is a base write landing between acknowledge pulses. Directed sequences build a three-deep case: level 3 is acknowledged, level 5 is held, level 1 nests and is retired, and then level 5 is released. A separate sequence writes the base high byte between the first and second pulses. Random rounds then mix mask writes, request bursts, acknowledges and end-of-interrupt writes against a bench model of pending, mask and in-service state.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    ACK_OP = 2'd0,
    ACK_LO = 2'd1,
    ACK_HI = 2'd2
  } ack_phase_e;

  localparam logic [7:0] CALL_OPCODE = 8'hCD;
  localparam int         ADDR_W      = 16;

  localparam logic [1:0] REG_MASK    = 2'd0;
  localparam logic [1:0] REG_BASE_LO = 2'd1;
  localparam logic [1:0] REG_BASE_HI = 2'd2;
  localparam logic [1:0] REG_EOI     = 2'd3;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N_REQ = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [N_REQ-1:0]  mask_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              eoi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '1;
      base_o <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        REG_MASK:    mask_o       <= wr_data_i[N_REQ-1:0];
        REG_BASE_LO: base_o[7:0]  <= wr_data_i;
        REG_BASE_HI: base_o[15:8] <= wr_data_i;
        default: ;
      endcase
    end
  end

  assign eoi_o = wr_en_i && (wr_addr_i == REG_EOI);
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int N_REQ = 8,
  localparam int LVL_W = $clog2(N_REQ)
) (
  input  logic [N_REQ-1:0] pend_i,
  input  logic [N_REQ-1:0] mask_i,
  input  logic [N_REQ-1:0] isr_i,
  output logic             any_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic [N_REQ-1:0] onehot_o
);
  logic [N_REQ-1:0] above_isr;
  logic [N_REQ-1:0] elig;

  // a level is allowed only if no in-service bit sits at or above it
  assign above_isr[0] = ~isr_i[0];
  for (genvar i = 1; i < N_REQ; i++) begin : g_above
    assign above_isr[i] = above_isr[i-1] & ~isr_i[i];
  end

  assign elig  = pend_i & ~mask_i & above_isr;
  assign any_o = |elig;

  always_comb begin
    lvl_o    = '0;
    onehot_o = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (elig[i]) begin
        lvl_o    = LVL_W'(i);
        onehot_o = '0;
        onehot_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_ack_seq.sv
module intc_ack_seq
  import intc_pkg::*;
#(
  parameter int N_REQ       = 8,
  parameter int SPACE_SHIFT = 2,
  localparam int LVL_W = $clog2(N_REQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inta_i,
  input  logic              any_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              take_o,
  output logic              busy_o,
  output ack_phase_e        phase_o,
  output logic [7:0]        data_o,
  output logic              data_oe_o
);
  logic              inta_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rise, fall;

  assign rise   = inta_i & ~inta_q;
  assign fall   = ~inta_i & inta_q;
  assign take_o = rise && (phase_o == ACK_OP) && any_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inta_q  <= 1'b0;
      phase_o <= ACK_OP;
      addr_q  <= '0;
    end else begin
      inta_q <= inta_i;
      if (rise && phase_o == ACK_OP)
        addr_q <= base_i + (ADDR_W'(lvl_i) << SPACE_SHIFT);
      if (fall) begin
        case (phase_o)
          ACK_OP:  phase_o <= ACK_LO;
          ACK_LO:  phase_o <= ACK_HI;
          default: phase_o <= ACK_OP;
        endcase
      end
    end
  end

  assign busy_o = (phase_o != ACK_OP) || inta_q;

  always_comb begin
    data_o = '0;
    if (inta_i) begin
      case (phase_o)
        ACK_OP:  data_o = CALL_OPCODE;
        ACK_LO:  data_o = addr_q[7:0];
        default: data_o = addr_q[15:8];
      endcase
    end
  end

  assign data_oe_o = inta_i;
endmodule

// File: rtl/vec_call_intc.sv
module vec_call_intc
  import intc_pkg::*;
#(
  parameter int N_REQ       = 8,
  parameter int SPACE_SHIFT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  output logic             int_o,
  input  logic             inta_i,
  output logic [7:0]       data_o,
  output logic             data_oe_o,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i
);
  localparam int LVL_W = $clog2(N_REQ);

  logic [N_REQ-1:0]  mask_w;
  logic [ADDR_W-1:0] base_w;
  logic              eoi_w;
  logic [N_REQ-1:0]  pend_q, isr_q, isr_after_eoi;
  logic              any_w, take_w, busy_w;
  logic [LVL_W-1:0]  lvl_w;
  logic [N_REQ-1:0]  onehot_w;
  ack_phase_e        phase_w;

  intc_regs #(.N_REQ(N_REQ)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .mask_o    (mask_w),
    .base_o    (base_w),
    .eoi_o     (eoi_w)
  );

  intc_prio #(.N_REQ(N_REQ)) u_prio (
    .pend_i   (pend_q),
    .mask_i   (mask_w),
    .isr_i    (isr_q),
    .any_o    (any_w),
    .lvl_o    (lvl_w),
    .onehot_o (onehot_w)
  );

  intc_ack_seq #(.N_REQ(N_REQ), .SPACE_SHIFT(SPACE_SHIFT)) u_ack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inta_i    (inta_i),
    .any_i     (any_w),
    .lvl_i     (lvl_w),
    .base_i    (base_w),
    .take_o    (take_w),
    .busy_o    (busy_w),
    .phase_o   (phase_w),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );

  // non-specific EOI retires the lowest set index
  assign isr_after_eoi = eoi_w ? (isr_q & (isr_q - 1'b1)) : isr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      isr_q  <= '0;
    end else begin
      pend_q <= (pend_q | req_i) & ~(take_w ? onehot_w : '0);
      isr_q  <= isr_after_eoi | (take_w ? onehot_w : '0);
    end
  end

  assign int_o = any_w & ~busy_w;
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int N_REQ = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             int_o,
  input logic             inta_i,
  input logic [7:0]       data_o,
  input logic             data_oe_o,
  input logic             eoi_w,
  input logic [N_REQ-1:0] mask_w,
  input logic [N_REQ-1:0] pend_q,
  input logic [N_REQ-1:0] isr_q,
  input ack_phase_e       phase_w
);
  logic inta_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inta_d <= 1'b0;
    else         inta_d <= inta_i;
  end

  assert_masked_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> |(pend_q & ~mask_w));

  assert_opcode_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && phase_w == ACK_OP) |-> data_o == CALL_OPCODE);

  assert_quiet_in_seq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_w != ACK_OP) |-> !int_o);

  assert_isr_grows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_o && inta_i && !inta_d && !eoi_w && phase_w == ACK_OP)
      |=> $countones(isr_q) == $past($countones(isr_q)) + 1);

  assert_bus_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inta_i |-> (!data_oe_o && data_o == 8'h00));
endmodule

bind vec_call_intc intc_checker #(.N_REQ(N_REQ)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .int_o     (int_o),
  .inta_i    (inta_i),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .eoi_w     (eoi_w),
  .mask_w    (mask_w),
  .pend_q    (pend_q),
  .isr_q     (isr_q),
  .phase_w   (phase_w)
);

// File: tb/vec_call_intc_tb.sv
module vec_call_intc_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         inta = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [7:0]   wr_data = '0;
  logic         int_o, data_oe_o;
  logic [7:0]   data_o;

  int errors = 0;
  int checks = 0;

  logic [N-1:0] m_pend = '0, m_mask = '1, m_isr = '0;
  logic [15:0]  m_base = '0;

  always #5 clk = ~clk;

  vec_call_intc #(.N_REQ(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .int_o(int_o), .inta_i(inta),
    .data_o(data_o), .data_oe_o(data_oe_o),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] elig();
    logic [N-1:0] ok = '0;
    logic blocked = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (m_isr[i]) blocked = 1'b1;
      ok[i] = m_pend[i] & ~m_mask[i] & ~blocked;
    end
    return ok;
  endfunction

  function automatic int win(input logic [N-1:0] e);
    for (int i = 0; i < N; i++) if (e[i]) return i;
    return -1;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    case (a)
      2'd0: m_mask = d[N-1:0];
      2'd1: m_base[7:0] = d;
      2'd2: m_base[15:8] = d;
      default: m_isr = m_isr & (m_isr - 1'b1);
    endcase
  endtask

  task automatic raise(input logic [N-1:0] bits);
    @(negedge clk); req = bits;
    @(negedge clk); req = '0;
    m_pend |= bits;
  endtask

  task automatic chk_int(input string tag);
    chk(int_o == |elig(), tag, int_o, |elig());
  endtask

  // full three-pulse acknowledge; optional base-high write between pulses 1 and 2
  task automatic do_ack(input string tag, input bit mid_wr, input logic [7:0] mid_hi);
    logic [N-1:0] e = elig();
    int w = win(e);
    logic [15:0] ea = m_base + 16'(w * 4);
    @(negedge clk); inta = 1'b1; #1;
    chk(data_oe_o && data_o == 8'hCD, "R4 opcode", data_o, 8'hCD);
    @(negedge clk);
    chk(int_o == 1'b0, "R7 int low in sequence", int_o, 0);
    m_isr[w] = 1'b1; m_pend[w] = 1'b0;
    inta = 1'b0; #1;
    chk(!data_oe_o && data_o == 8'h00, "R10 idle bus", {data_oe_o, data_o}, 0);
    if (mid_wr) wr(2'd2, mid_hi);
    @(negedge clk); inta = 1'b1; #1;
    chk(data_o == ea[7:0], {tag, " low byte"}, data_o, ea[7:0]);
    @(negedge clk); inta = 1'b0;
    @(negedge clk); chk(int_o == 1'b0, "R7 int low between pulses", int_o, 0);
    inta = 1'b1; #1;
    chk(data_o == ea[15:8], {tag, " high byte"}, data_o, ea[15:8]);
    @(negedge clk); inta = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!int_o && !data_oe_o && data_o == 0, "R1 reset outputs", {int_o, data_oe_o, data_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    raise(8'h01);
    chk(int_o == 1'b0, "R1 mask set after reset", int_o, 0);
    wr(2'd0, 8'h01);
    chk(int_o == 1'b0, "R3 masked line quiet", int_o, 0);
    wr(2'd0, 8'h00);
    chk(int_o == 1'b1, "R3 unmask raises latched request", int_o, 1);
    chk(int_o == 1'b1, "R2 request held after line dropped", int_o, 1);
    wr(2'd1, 8'h30); wr(2'd2, 8'h12);
    do_ack("R5 level0", 1'b0, 8'h00);
    chk(int_o == 1'b0, "R7 no re-raise after ack", int_o, 0);
    raise(8'h01);
    chk(int_o == 1'b0, "R8 equal level held", int_o, 0);
    wr(2'd3, 8'h00);
    chk(int_o == 1'b1, "R8 eoi releases held", int_o, 1);
    do_ack("R5 level0 again", 1'b0, 8'h00);
    wr(2'd3, 8'h00);
    raise(8'h28);
    chk(int_o == 1'b1, "R2 two requests", int_o, 1);
    do_ack("R6 level3 wins", 1'b0, 8'h00);
    chk(int_o == 1'b0, "R8 lower level held", int_o, 0);
    raise(8'h02);
    chk(int_o == 1'b1, "R9 nesting raises int", int_o, 1);
    do_ack("R9 nested level1", 1'b0, 8'h00);
    wr(2'd3, 8'h00);
    chk(int_o == 1'b0, "R8 eoi retires highest only", int_o, 0);
    wr(2'd3, 8'h00);
    chk(int_o == 1'b1, "R8 second eoi releases level5", int_o, 1);
    do_ack("R5 level5", 1'b0, 8'h00);
    wr(2'd3, 8'h00);
    raise(8'h04);
    do_ack("R11 captured address", 1'b1, 8'h55);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'hFE); wr(2'd2, 8'hFF);
    raise(8'h02);
    do_ack("R5 wrap", 1'b0, 8'h00);
    wr(2'd3, 8'h00);
    chk_int("R2 idle after directed");

    for (int it = 0; it < 80; it++) begin
      case ($urandom % 4)
        0: wr(2'd0, 8'($urandom & $urandom & $urandom));
        1: raise(N'($urandom));
        2: if (|elig()) do_ack("R5 random", 1'b0, 8'h00);
        default: wr(2'd3, 8'h00);
      endcase
      chk_int("R6 random int level");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule